// File: doc/BRIEF.md
# Software Interrupt Request Register with Level Masking

This block keeps a 17-bit word of software interrupt requests and turns it into per-level pending signals for a processor core. Software changes the word over a small register bus. It can replace the whole word, OR bits into it through a set alias, or clear bits through a clear alias. A 4-bit interrupt level register, written over the same bus, decides which requests are passed on as pending. Two hardware strobes from the timer-compare logic set the two timer-match bits directly, with no bus access needed.

The two timer-match bits (bit 0 for the cycle-timer match and bit 16 for the system-timer match) follow their own masking rule. They are pending only while the level is below a fixed threshold of 14. Each of bits 1 to 15 is pending only when its index is strictly greater than the level. The pending vector and an any-pending flag are registered outputs. They follow the register and the level one clock later. Trap vectoring, acknowledge and the timers themselves belong to the neighbouring logic.

Top module: `softint_ctrl`

## Requirements
- R1: A bus write with select code 1 (set alias) ORs bits 16..0 of the write data into the request word.
- R2: A bus write with select code 2 (clear alias) clears every request bit whose write-data bit is 1 and leaves the other bits unchanged.
- R3: A bus write with select code 0 (direct) replaces the request word with bits 16..0 of the write data. Write-data bits above 16 are discarded.
- R4: A bus write with select code 3 stores bits 3..0 of the write data as the interrupt level. A read with select 3 returns the level zero-extended.
- R5: For each index i from 1 to 15, pending bit i is 1 exactly when request bit i is 1 and i is strictly greater than the level.
- R6: Pending bits 0 and 16 are 1 exactly when the matching request bit is 1 and the level is below 14.
- R7: The tick_match strobe sets request bit 0 and the sys_match strobe sets request bit 16 at the clock edge where they are high. A strobe wins over any bus write made to the same bit in that cycle.
- R8: Reset clears the request word, the level, the pending vector and the any-pending flag.
- R9: The pending vector reflects the request word and level one clock after they change. any_pend is 1 exactly when some pending bit is 1.
- R10: A read with select 0, 1 or 2 returns the request word with all bits above 16 zero. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 2 | Write target: 0 direct, 1 set alias, 2 clear alias, 3 level |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | DATA_W | Read data, combinational from rd_sel |
| tick_match | input | 1 | Cycle-timer match strobe, sets request bit 0 |
| sys_match | input | 1 | System-timer match strobe, sets request bit 16 |
| pend | output | 17 | Registered per-bit pending vector |
| any_pend | output | 1 | High when any pending bit is set |

## Verification
The embedded properties assume that wr_sel, wr_data and the two strobes are stable across each rising edge. They also assume that a clear-alias write is judged only in cycles where no strobe is high, since a strobe may legally put a cleared bit back. The stimulus changes every input on the falling edge and holds it for a full cycle. It raises the strobes together with a write only in the directed tests meant to exercise their priority. The level-gating properties compare each pending bit against the level of the previous cycle. The bench therefore always waits one extra edge after a level or word change before it judges the pending outputs.

// File: rtl/softint_pkg.sv
package softint_pkg;

   // Register-bus target encoding; shared by the write and read paths.
   typedef enum logic [1:0] {
      SEL_DIRECT = 2'd0,
      SEL_SET    = 2'd1,
      SEL_CLEAR  = 2'd2,
      SEL_LEVEL  = 2'd3
   } reg_sel_e;

   // Default geometry of the request word and the level field.
   localparam int unsigned DEF_REQ_BITS  = 17;
   localparam int unsigned DEF_LVL_BITS  = 4;
   localparam int unsigned DEF_TIMER_THR = 14;

endpackage

// File: rtl/softint_store.sv
module softint_store
   import softint_pkg::*;
#(
   parameter int unsigned REQ_BITS = DEF_REQ_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  reg_sel_e            wr_sel,
   input  logic [REQ_BITS-1:0] wr_data,
   input  logic                stb_lo,
   input  logic                stb_hi,
   output logic [REQ_BITS-1:0] req_q
);

   localparam int unsigned TOP = REQ_BITS - 1;

   logic [REQ_BITS-1:0] req_bus;
   logic [REQ_BITS-1:0] req_d;
   logic [REQ_BITS-1:0] stb_vec;

   // Bus-side update: the alias decides how the write data combines.
   always_comb begin
      req_bus = req_q;
      if (wr_en) begin
         case (wr_sel)
            SEL_DIRECT: req_bus = wr_data;
            SEL_SET:    req_bus = req_q | wr_data;
            SEL_CLEAR:  req_bus = req_q & ~wr_data;
            default:    req_bus = req_q;
         endcase
      end
   end

   // Strobe bits are ORed last so they win over any same-cycle write.
   always_comb begin
      stb_vec      = '0;
      stb_vec[0]   = stb_lo;
      stb_vec[TOP] = stb_hi;
      req_d        = req_bus | stb_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_d;
   end

   a_r1_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_SET)
      |=> ((req_q & $past(wr_data)) == $past(wr_data)));

   a_r2_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_CLEAR && !stb_lo && !stb_hi)
      |=> ((req_q & $past(wr_data)) == '0));

   a_r3_direct_replace: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_DIRECT && !stb_lo && !stb_hi)
      |=> (req_q == $past(wr_data)));

   a_r7_strobe_lo: assert property (@(posedge clk) disable iff (!rst_n)
      stb_lo |=> req_q[0]);

   a_r7_strobe_hi: assert property (@(posedge clk) disable iff (!rst_n)
      stb_hi |=> req_q[TOP]);

endmodule

// File: rtl/softint_level.sv
module softint_level #(
   parameter int unsigned LVL_BITS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lvl_we,
   input  logic [LVL_BITS-1:0] lvl_wdata,
   output logic [LVL_BITS-1:0] lvl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= '0;
      else if (lvl_we) lvl_q <= lvl_wdata;
   end

   a_r4_level_store: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_we |=> (lvl_q == $past(lvl_wdata)));

   a_r4_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_we |=> $stable(lvl_q));

endmodule

// File: rtl/softint_mask.sv
module softint_mask #(
   parameter int unsigned REQ_BITS  = 17,
   parameter int unsigned LVL_BITS  = 4,
   parameter int unsigned TIMER_THR = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REQ_BITS-1:0] req,
   input  logic [LVL_BITS-1:0] lvl,
   output logic [REQ_BITS-1:0] pend_q
);

   localparam int unsigned TOP = REQ_BITS - 1;

   logic [REQ_BITS-1:0] hit;
   logic                timer_open;

   assign timer_open = (int'(lvl) < int'(TIMER_THR));

   // Timer-match bits use the fixed threshold; the rest use index > level.
   for (genvar i = 0; i < REQ_BITS; i++) begin : g_bit
      if (i == 0 || i == TOP) begin : g_timer
         assign hit[i] = req[i] & timer_open;
      end else begin : g_level
         assign hit[i] = req[i] & (int'(lvl) < i);

         a_r5_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[i] |-> (int'($past(lvl)) < i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= hit;
   end

   a_r6_timer_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[0] || pend_q[TOP]) |-> (int'($past(lvl)) < int'(TIMER_THR)));

endmodule

// File: rtl/softint_ctrl.sv
module softint_ctrl
   import softint_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned REQ_BITS  = DEF_REQ_BITS,
   parameter int unsigned LVL_BITS  = DEF_LVL_BITS,
   parameter int unsigned TIMER_THR = DEF_TIMER_THR
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [1:0]          rd_sel,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                tick_match,
   input  logic                sys_match,
   output logic [REQ_BITS-1:0] pend,
   output logic                any_pend
);

   localparam int unsigned MAX_LVL = (1 << LVL_BITS) - 1;

   // Elaboration-time parameter checks.
   if (REQ_BITS < 3) begin : g_chk_req
      $error("REQ_BITS must be at least 3");
   end
   if (DATA_W < REQ_BITS || DATA_W < LVL_BITS) begin : g_chk_data
      $error("DATA_W must cover the request word and the level");
   end
   if (REQ_BITS - 2 > MAX_LVL + 1) begin : g_chk_lvl
      $error("LVL_BITS too narrow for the request word");
   end
   if (TIMER_THR > MAX_LVL + 1) begin : g_chk_thr
      $error("TIMER_THR out of level range");
   end

   reg_sel_e            wsel;
   logic [REQ_BITS-1:0] req_q;
   logic [LVL_BITS-1:0] lvl_q;
   logic                lvl_we;
   logic [DATA_W-1:0]   rd_req;
   logic [DATA_W-1:0]   rd_lvl;

   assign wsel   = reg_sel_e'(wr_sel);
   assign lvl_we = wr_en && (wsel == SEL_LEVEL);

   softint_store #(.REQ_BITS(REQ_BITS)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wsel),
      .wr_data (wr_data[REQ_BITS-1:0]),
      .stb_lo  (tick_match),
      .stb_hi  (sys_match),
      .req_q   (req_q)
   );

   softint_level #(.LVL_BITS(LVL_BITS)) i_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_we    (lvl_we),
      .lvl_wdata (wr_data[LVL_BITS-1:0]),
      .lvl_q     (lvl_q)
   );

   softint_mask #(
      .REQ_BITS  (REQ_BITS),
      .LVL_BITS  (LVL_BITS),
      .TIMER_THR (TIMER_THR)
   ) i_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_q),
      .lvl    (lvl_q),
      .pend_q (pend)
   );

   assign any_pend = |pend;

   // Zero-extension of the read words; the padding exists only if wider.
   if (DATA_W > REQ_BITS) begin : g_req_pad
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data[DATA_W-1:REQ_BITS];
      assign rd_req = {{(DATA_W-REQ_BITS){1'b0}}, req_q};
   end else begin : g_req_full
      assign rd_req = req_q;
   end

   if (DATA_W > LVL_BITS) begin : g_lvl_pad
      assign rd_lvl = {{(DATA_W-LVL_BITS){1'b0}}, lvl_q};
   end else begin : g_lvl_full
      assign rd_lvl = lvl_q;
   end

   always_comb begin
      case (reg_sel_e'(rd_sel))
         SEL_LEVEL: rd_data = rd_lvl;
         default:   rd_data = rd_req;
      endcase
   end

   a_r5_pend_backed: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(req_q)) == '0));

   a_r9_pend_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(req_q) && $stable(lvl_q)) |=> $stable(pend));

endmodule

// File: tb/test_softint_ctrl.sv
module test_softint_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int VEC_N      = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = 2'd0;
   logic [31:0] rd_data;
   logic        tick_match = 1'b0;
   logic        sys_match = 1'b0;
   logic [16:0] pend;
   logic        any_pend;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   softint_ctrl i_softint_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .tick_match(tick_match), .sys_match(sys_match),
      .pend(pend), .any_pend(any_pend)
   );

   // {select, data, expected word, expected pending}; applied in order.
   localparam logic [52:0] VECS [VEC_N] = '{
      {2'd0, 17'h10001, 17'h10001, 17'h10001},  // R3 direct, level 0
      {2'd1, 17'h00020, 17'h10021, 17'h10021},  // R1 set bit 5
      {2'd3, 17'h00005, 17'h10021, 17'h10001},  // R5 bit 5 not above level 5
      {2'd1, 17'h08000, 17'h18021, 17'h18001},  // R1 R5 bit 15
      {2'd3, 17'h0000E, 17'h18021, 17'h08000},  // R6 level 14 masks timers
      {2'd2, 17'h08000, 17'h10021, 17'h00000},  // R2 clear bit 15
      {2'd3, 17'h0000D, 17'h10021, 17'h10001},  // R6 level 13 opens timers
      {2'd0, 17'h00F0F, 17'h00F0F, 17'h00001},  // R3 R5 low bits masked
      {2'd3, 17'h00000, 17'h00F0F, 17'h00F0F},  // R5 level 0
      {2'd2, 17'h1FFFF, 17'h00000, 17'h00000},  // R2 clear all
      {2'd1, 17'h1FFFF, 17'h1FFFF, 17'h1FFFF}   // R1 set all, level 0
   };

   task automatic check(input string req, input logic [31:0] got,
                        input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] s, input logic [31:0] d,
                            input logic lo, input logic hi);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d; tick_match = lo; sys_match = hi;
      @(negedge clk);
      wr_en = 1'b0; tick_match = 1'b0; sys_match = 1'b0; wr_data = '0;
   endtask

   task automatic bus_read(input logic [1:0] s, output logic [31:0] v);
      rd_sel = s;
      #1;
      v = rd_data;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] v2;

      repeat (3) @(negedge clk);
      // R8: reset state
      bus_read(2'd0, v); check("R8 word", v, 32'h0);
      bus_read(2'd3, v); check("R8 level", v, 32'h0);
      check("R8 pend", {15'h0, pend}, 32'h0);
      check("R8 any", {31'h0, any_pend}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < VEC_N; k++) begin
         bus_write(VECS[k][52:51], {15'h0, VECS[k][50:34]}, 1'b0, 1'b0);
         bus_read(2'd0, v);
         check("R1/R2/R3 word", v, {15'h0, VECS[k][33:17]});
         @(negedge clk);
         check("R5/R6 pend", {15'h0, pend}, {15'h0, VECS[k][16:0]});
         check("R9 any", {31'h0, any_pend}, {31'h0, |VECS[k][16:0]});
      end

      // R9: one-clock latency after a level change (word 1FFFF)
      bus_write(2'd3, 32'hF, 1'b0, 1'b0);
      check("R9 pend before update", {15'h0, pend}, 32'h1FFFF);
      @(negedge clk);
      check("R9 pend after level 15", {15'h0, pend}, 32'h0);
      check("R9 any cleared", {31'h0, any_pend}, 32'h0);
      bus_write(2'd3, 32'h0, 1'b0, 1'b0);
      check("R9 pend held one clock", {15'h0, pend}, 32'h0);
      @(negedge clk);
      check("R9 pend restored", {15'h0, pend}, 32'h1FFFF);

      // R3: upper write bits discarded; R10: upper read bits zero
      bus_write(2'd0, 32'hFFFE_0000, 1'b0, 1'b0);
      bus_read(2'd0, v); check("R3 upper bits dropped", v, 32'h0);
      bus_write(2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      bus_read(2'd1, v); check("R10 read via set alias", v, 32'h1FFFF);
      bus_read(2'd2, v); check("R10 read via clear alias", v, 32'h1FFFF);

      // R4: level keeps low four bits, read zero-extended
      bus_write(2'd3, 32'hFFFF_FFF7, 1'b0, 1'b0);
      bus_read(2'd3, v); check("R4 level read", v, 32'h7);

      // R10: repeated reads leave state untouched
      bus_read(2'd0, v);
      repeat (3) @(negedge clk);
      bus_read(2'd0, v2); check("R10 word stable", v2, v);
      bus_read(2'd3, v2); check("R10 level stable", v2, 32'h7);
      check("R10 pend stable", {15'h0, pend}, 32'h1FF01);

      // R7: strobes beat a same-cycle clear of bits 0 and 16
      bus_write(2'd0, 32'h0, 1'b0, 1'b0);
      bus_write(2'd2, 32'h1_0001, 1'b1, 1'b1);
      bus_read(2'd0, v); check("R7 strobe over clear", v, 32'h10001);
      @(negedge clk);
      check("R7 pend timers", {15'h0, pend}, 32'h10001);
      bus_write(2'd1, 32'h0, 1'b0, 1'b1);
      bus_write(2'd0, 32'h0, 1'b0, 1'b1);
      bus_read(2'd0, v); check("R7 system strobe over direct", v, 32'h10000);
      bus_write(2'd0, 32'h2, 1'b1, 1'b0);
      bus_read(2'd0, v); check("R7 tick strobe over direct", v, 32'h3);

      // R8: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      bus_read(2'd0, v); check("R8 word after reset", v, 32'h0);
      bus_read(2'd3, v); check("R8 level after reset", v, 32'h0);
      check("R8 pend after reset", {15'h0, pend}, 32'h0);
      check("R8 any after reset", {31'h0, any_pend}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   end

endmodule